// File: doc/BRIEF.md
# Dual-Ramp ADC Linearity Estimator

This block turns two code histograms of an ADC under test into per-code linearity figures. Both histograms come from the same imprecise ramp. The second run uses that ramp shifted by an unknown constant offset. Taken together, the two histograms let the block separate the converter's own nonlinearity from the ramp's. The block estimates the shift and then reports the integral and differential nonlinearity of every code. It also reports the largest magnitude of each.

Software or a test sequencer fills the two histogram memories and pulses `start`. The block reads both counts of a code through a single read port in one pass, in ascending code order. It computes one reciprocal term per code with a sequential divider and keeps each term. A second divide then gives the shift estimate. A second pass over the stored terms emits one result per code on a valid/ready stream. The stream holds each beat until the consumer accepts it, and it does not advance without a handshake. After the last beat is accepted, the two maxima are presented with a one-cycle `done` pulse. If a count or denominator is degenerate, the run stops and a one-cycle `err` pulse reports the code that caused it.

All values are fixed point with `FRAC` fractional bits. A result of 1.0 is 1 LSB, stored as `2^FRAC`. Let N = 2^`CODE_W` and L = N-2.

Top module: `dual_ramp_lin_est`

## Requirements
- R1: A `start` pulse while idle reads codes 0,1,...,L, once each, in ascending order. The counts `rd_c1`/`rd_c2` are sampled on the cycle after `rd_en`. `busy` stays high from the cycle after `start` until the cycle after `done` or `err`.
- R2: For k=1..L, let S1 be the sum of C1 over codes 0..k and S2 the sum of C2 over codes 0..k-1. Let D = S1-S2. The stored term is r_k = floor(2·C1_k·C2_k·2^FRAC / (2·C1_k·C2_k − D·(C1_k+C2_k))).
- R3: The shift estimate is alpha = floor(L·2^(2·FRAC) / Σr_k), summed over k=1..L.
- R4: The DNL of code k (k=1..L) is floor(alpha·r_k / 2^FRAC) − 2^FRAC.
- R5: The INL of code k (k=1..L-1) is floor(alpha·(r_1+…+r_k) / 2^FRAC) − k·2^FRAC. The INL of code L is reported as exactly 0.
- R6: The result stream carries codes 1..L in ascending order on `res_code`. While `res_valid` is high and `res_ready` is low, the code, INL and DNL stay unchanged. A code is consumed only on a cycle with both high.
- R7: On the cycle after the final handshake, `done` is high for exactly one cycle. `peak_inl` and `peak_dnl` then hold the largest |INL| and the largest |DNL| over the streamed codes.
- R8: A zero C1 or C2 count at any code k in 1..L aborts the run. `err` pulses once, `err_code` = k, no result is streamed and `done` does not pulse. Zero counts at code 0 or code N-1 are not errors.
- R9: A denominator in R2 that is zero or negative at code k aborts the run in the same way, with `err_code` = k. A zero Σr aborts with `err_code` = 0.
- R10: After reset, `busy`, `res_valid`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an estimate (ignored while busy) |
| busy | output | 1 | Estimate in progress |
| rd_en | output | 1 | Histogram read strobe |
| rd_addr | output | CODE_W | Code being read |
| rd_c1 | input | CNT_W | Count of that code in the first histogram, one cycle after rd_en |
| rd_c2 | input | CNT_W | Count of that code in the shifted histogram, one cycle after rd_en |
| res_valid | output | 1 | Result beat available |
| res_ready | input | 1 | Consumer accepts the beat |
| res_code | output | CODE_W | Code of the current beat |
| res_inl | output | RES_W | Signed INL of that code, FRAC fractional bits |
| res_dnl | output | RES_W | Signed DNL of that code, FRAC fractional bits |
| done | output | 1 | One-cycle pulse; maxima valid |
| err | output | 1 | One-cycle abort pulse |
| err_code | output | CODE_W | Code that caused the abort (0 for a zero sum) |
| peak_inl | output | RES_W | Largest INL magnitude |
| peak_dnl | output | RES_W | Largest DNL magnitude |

## Verification
Each run is checked for every code against values computed from R2 to R5. The runs cover uniform histograms, where INL and DNL must come out exactly zero, and non-uniform histograms, where a wrong running-sum alignment (S2 taken through code k instead of k-1) shifts every term. The last code must read as zero INL, while its DNL still comes from the formula. A design that forgot the end-point override would show a nonzero INL there. Back-pressure from an irregular ready pattern exposes a stream that drops or repeats codes. Zero counts at code 7, a zero shift that makes the denominator zero at code 1, and zero counts at codes 0 and N-1 separate a correct abort from a false abort or a missed one.

// File: rtl/dnl_est_pkg.sv
package dnl_est_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_RD0, ST_CAP0, ST_RD, ST_CAP, ST_DIV,
    ST_ALPHA, ST_ADIV, ST_OUT, ST_DONE, ST_ERR
  } est_state_t;
endpackage

// File: rtl/dnl_seq_div.sv
module dnl_seq_div #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quotient
);
  localparam int CW = $clog2(W + 1);

  logic [W:0]    rem;
  logic [W-1:0]  quo, dvs;
  logic [CW-1:0] cnt;
  logic          run;
  logic [W:0]    shifted;
  logic          take;

  always_comb begin
    shifted = {rem[W-1:0], quo[W-1]};
    take    = shifted >= {1'b0, dvs};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem <= '0; quo <= '0; dvs <= '0; cnt <= '0; run <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem <= '0; quo <= dividend; dvs <= divisor; cnt <= '0; run <= 1'b1;
      end else if (run) begin
        rem <= take ? (shifted - {1'b0, dvs}) : shifted;
        quo <= {quo[W-2:0], take};
        cnt <= cnt + 1'b1;
        if (cnt == CW'(W - 1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quotient = quo;

  AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> divisor != '0); // R9
endmodule

// File: rtl/dnl_term_store.sv
module dnl_term_store #(
  parameter int AW    = 4,
  parameter int W     = 64,
  parameter int LAST  = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [0:LAST];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

  AST_WR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (waddr >= AW'(1) && waddr <= AW'(LAST))); // R2
endmodule

// File: rtl/dnl_peak_track.sv
module dnl_peak_track #(
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                upd,
  input  logic signed [W-1:0] val,
  output logic [W-1:0]        peak
);
  logic [W-1:0] mag;
  assign mag = val[W-1] ? $unsigned(-val) : $unsigned(val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 peak <= '0;
    else if (clr)               peak <= '0;
    else if (upd && mag > peak) peak <= mag;
  end

  AST_PEAK_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> peak >= $past(peak)); // R7
endmodule

// File: rtl/dual_ramp_lin_est.sv
module dual_ramp_lin_est
  import dnl_est_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 10,
  parameter int FRAC   = 12,
  parameter int ACC_W  = 64,
  parameter int RES_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              rd_en,
  output logic [CODE_W-1:0] rd_addr,
  input  logic [CNT_W-1:0]  rd_c1,
  input  logic [CNT_W-1:0]  rd_c2,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [CODE_W-1:0] res_code,
  output logic [RES_W-1:0]  res_inl,
  output logic [RES_W-1:0]  res_dnl,
  output logic              done,
  output logic              err,
  output logic [CODE_W-1:0] err_code,
  output logic [RES_W-1:0]  peak_inl,
  output logic [RES_W-1:0]  peak_dnl
);
  localparam int NCODE = 1 << CODE_W;
  localparam int LAST  = NCODE - 2;
  localparam logic [CODE_W-1:0] LAST_C = CODE_W'(LAST);
  localparam logic [ACC_W-1:0]  ONE_FX = ACC_W'(1) << FRAC;
  localparam logic [ACC_W-1:0]  ALPHA_NUM = ACC_W'(LAST) << (2 * FRAC);

  est_state_t st;
  logic [CODE_W-1:0]       k;
  logic signed [ACC_W-1:0] s1, s2;
  logic [ACC_W-1:0]        rsum, psum, alpha;

  // ---- first sweep: per-code reciprocal term
  logic signed [ACC_W-1:0] c1x, c2x, s1n, dk, num, den;
  logic                    zero_cnt, bad_den;

  always_comb begin
    c1x      = ACC_W'(rd_c1);
    c2x      = ACC_W'(rd_c2);
    s1n      = s1 + c1x;
    dk       = s1n - s2;
    num      = 2 * c1x * c2x;
    den      = num - dk * (c1x + c2x);
    zero_cnt = (rd_c1 == '0) || (rd_c2 == '0);
    bad_den  = den <= 0;
  end

  logic             div_start, div_done;
  logic [ACC_W-1:0] div_a, div_b, div_q;

  always_comb begin
    div_start = ((st == ST_CAP) && !zero_cnt && !bad_den) ||
                ((st == ST_ALPHA) && (rsum != '0));
    div_a     = (st == ST_ALPHA) ? ALPHA_NUM : ($unsigned(num) << FRAC);
    div_b     = (st == ST_ALPHA) ? rsum : $unsigned(den);
  end

  dnl_seq_div #(.W(ACC_W)) div_i (
    .clk(clk), .rst_n(rst_n), .start(div_start), .dividend(div_a),
    .divisor(div_b), .done(div_done), .quotient(div_q)
  );

  logic             st_we;
  logic [ACC_W-1:0] r_k;
  assign st_we = (st == ST_DIV) && div_done;

  dnl_term_store #(.AW(CODE_W), .W(ACC_W), .LAST(LAST)) store_i (
    .clk(clk), .rst_n(rst_n), .we(st_we), .waddr(k), .wdata(div_q),
    .raddr(k), .rdata(r_k)
  );

  // ---- second sweep: per-code results
  logic [ACC_W-1:0]        prod_d, prod_i, psum_n;
  logic signed [ACC_W-1:0] dnl_full, inl_full;
  logic                    hs;

  always_comb begin
    psum_n   = psum + r_k;
    prod_d   = alpha * r_k;
    prod_i   = alpha * psum_n;
    dnl_full = $signed(prod_d >> FRAC) - $signed(ONE_FX);
    inl_full = (k == LAST_C) ? '0
             : $signed(prod_i >> FRAC) - $signed(ACC_W'(k) << FRAC);
  end

  assign res_valid = (st == ST_OUT);
  assign hs        = res_valid && res_ready;
  assign res_code  = k;
  assign res_inl   = inl_full[RES_W-1:0];
  assign res_dnl   = dnl_full[RES_W-1:0];
  assign busy      = (st != ST_IDLE);
  assign rd_en     = (st == ST_RD0) || (st == ST_RD);
  assign rd_addr   = (st == ST_RD0) ? '0 : k;
  assign done      = (st == ST_DONE);
  assign err       = (st == ST_ERR);

  logic pk_clr;
  assign pk_clr = (st == ST_IDLE) && start;

  dnl_peak_track #(.W(RES_W)) pk_inl_i (
    .clk(clk), .rst_n(rst_n), .clr(pk_clr), .upd(hs), .val(res_inl), .peak(peak_inl)
  );
  dnl_peak_track #(.W(RES_W)) pk_dnl_i (
    .clk(clk), .rst_n(rst_n), .clr(pk_clr), .upd(hs), .val(res_dnl), .peak(peak_dnl)
  );

  // ---- sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; k <= '0; s1 <= '0; s2 <= '0;
      rsum <= '0; psum <= '0; alpha <= '0; err_code <= '0;
    end else begin
      unique case (st)
        ST_IDLE:  if (start) st <= ST_RD0;
        ST_RD0:   st <= ST_CAP0;
        ST_CAP0: begin
          s1 <= c1x; s2 <= c2x; rsum <= '0; k <= CODE_W'(1); st <= ST_RD;
        end
        ST_RD:    st <= ST_CAP;
        ST_CAP: begin
          if (zero_cnt || bad_den) begin
            err_code <= k; st <= ST_ERR;
          end else begin
            s1 <= s1n; s2 <= s2 + c2x; st <= ST_DIV;
          end
        end
        ST_DIV: begin
          if (div_done) begin
            rsum <= rsum + div_q;
            if (k == LAST_C) st <= ST_ALPHA;
            else begin k <= k + 1'b1; st <= ST_RD; end
          end
        end
        ST_ALPHA: begin
          if (rsum == '0) begin err_code <= '0; st <= ST_ERR; end
          else st <= ST_ADIV;
        end
        ST_ADIV: begin
          if (div_done) begin
            alpha <= div_q; k <= CODE_W'(1); psum <= '0; st <= ST_OUT;
          end
        end
        ST_OUT: begin
          if (hs) begin
            psum <= psum_n;
            if (k == LAST_C) st <= ST_DONE;
            else k <= k + 1'b1;
          end
        end
        ST_DONE:  st <= ST_IDLE;
        ST_ERR:   st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_code) &&
                                   $stable(res_inl) && $stable(res_dnl))); // R6
  AST_FIRST_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> res_code == CODE_W'(1)); // R6
  AST_RD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> rd_addr <= LAST_C); // R1
  AST_ERR_NO_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !res_valid && !done); // R8
endmodule

// File: tb/dual_ramp_lin_est_tb_top.sv
module dual_ramp_lin_est_tb_top;
  localparam int CW = 4;
  localparam int NC = 16;
  localparam int LC = NC - 2;
  localparam int F  = 12;
  localparam int RW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, rd_en, res_valid, done, err;
  logic res_ready = 1'b0;
  logic [CW-1:0] rd_addr, res_code, err_code;
  logic [9:0] rd_c1, rd_c2;
  logic [RW-1:0] res_inl, res_dnl, peak_inl, peak_dnl;

  always #4 clk = ~clk;

  dual_ramp_lin_est dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_c1(rd_c1), .rd_c2(rd_c2),
    .res_valid(res_valid), .res_ready(res_ready), .res_code(res_code),
    .res_inl(res_inl), .res_dnl(res_dnl), .done(done), .err(err),
    .err_code(err_code), .peak_inl(peak_inl), .peak_dnl(peak_dnl)
  );

  int h1 [NC];
  int h2 [NC];
  int rd_log [32];
  int rd_n;
  int checks = 0;
  int errors = 0;

  always @(posedge clk) begin
    if (rd_en) begin
      rd_c1 <= 10'(h1[rd_addr]);
      rd_c2 <= 10'(h2[rd_addr]);
      if (rd_n < 32) rd_log[rd_n] <= int'(rd_addr);
      rd_n <= rd_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  longint e_inl [NC];
  longint e_dnl [NC];
  longint e_pinl, e_pdnl;
  int     e_err, e_code;

  task automatic model();
    longint s1, s2, rs, d, num, den, alpha, p, a;
    longint r [NC];
    e_err = 0; e_code = 0; rs = 0; e_pinl = 0; e_pdnl = 0;
    s1 = h1[0]; s2 = h2[0];
    for (int k = 1; k <= LC; k++) begin
      if (e_err == 0) begin
        if (h1[k] == 0 || h2[k] == 0) begin e_err = 1; e_code = k; end
        else begin
          s1 += h1[k];
          d   = s1 - s2;
          num = 2 * longint'(h1[k]) * h2[k];
          den = num - d * (h1[k] + h2[k]);
          if (den <= 0) begin e_err = 1; e_code = k; end
          else begin r[k] = (num << F) / den; rs += r[k]; end
          s2 += h2[k];
        end
      end
    end
    if (e_err == 0 && rs == 0) begin e_err = 1; e_code = 0; end
    if (e_err == 0) begin
      alpha = (longint'(LC) << (2 * F)) / rs;
      p = 0;
      for (int k = 1; k <= LC; k++) begin
        p += r[k];
        e_dnl[k] = ((alpha * r[k]) >>> F) - (longint'(1) << F);
        e_inl[k] = (k == LC) ? 0 : ((alpha * p) >>> F) - (longint'(k) << F);
        a = e_dnl[k] < 0 ? -e_dnl[k] : e_dnl[k];
        if (a > e_pdnl) e_pdnl = a;
        a = e_inl[k] < 0 ? -e_inl[k] : e_inl[k];
        if (a > e_pinl) e_pinl = a;
      end
    end
  endtask

  task automatic run_case(input string name, input int rmode);
    int items, cyc;
    bit fin, stalled;
    logic [CW-1:0] st_code;
    logic [RW-1:0] st_inl;
    model();
    rd_n = 0; items = 0; fin = 0; stalled = 0; st_code = '0; st_inl = '0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, {"R1 busy after start ", name}, busy, 1);
    for (cyc = 0; cyc < 6000 && !fin; cyc++) begin
      @(negedge clk);
      res_ready = (rmode == 0) ? 1'b1 : ((cyc % 3) != 1 && (cyc % 7) != 2);
      if (stalled) begin
        chk(res_valid && res_code == st_code && res_inl == st_inl,
            {"R6 hold under stall ", name}, res_code, st_code);
        stalled = 0;
      end
      if (err) begin
        fin = 1;
        chk(e_err == 1, {"R8/R9 unexpected abort ", name}, err_code, -1);
        chk(err_code == CW'(e_code), {"R8/R9 abort code ", name}, err_code, e_code);
        chk(items == 0, {"R8 no stream on abort ", name}, items, 0);
      end else if (done) begin
        fin = 1;
        chk(e_err == 0, {"R9 missing abort ", name}, 0, 1);
        chk(items == LC, {"R6 beat count ", name}, items, LC);
        chk(longint'(peak_inl) == e_pinl, {"R7 peak INL ", name}, peak_inl, e_pinl);
        chk(longint'(peak_dnl) == e_pdnl, {"R7 peak DNL ", name}, peak_dnl, e_pdnl);
        chk(rd_n == LC + 1, {"R1 read count ", name}, rd_n, LC + 1);
        for (int i = 0; i <= LC && i < rd_n; i++)
          chk(rd_log[i] == i, {"R1 read order ", name}, rd_log[i], i);
      end else if (res_valid) begin
        if (res_ready) begin
          items++;
          chk(res_code == CW'(items), {"R6 code order ", name}, res_code, items);
          chk(longint'($signed(res_dnl)) == e_dnl[items], {"R4 DNL ", name},
              longint'($signed(res_dnl)), e_dnl[items]);
          chk(longint'($signed(res_inl)) == e_inl[items],
              (items == LC) ? {"R5 last INL zero ", name} : {"R5 INL ", name},
              longint'($signed(res_inl)), e_inl[items]);
        end else begin
          stalled = 1; st_code = res_code; st_inl = res_inl;
        end
      end
    end
    res_ready = 1'b0;
    chk(fin, {"R1 run completes ", name}, fin, 1);
    @(negedge clk);
    chk(!done && !err && !busy, {"R7 single pulse then idle ", name}, done, 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !res_valid && !done && !err, "R10 reset state", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !res_valid && !done && !err, "R10 idle after reset", busy, 0);

    // uniform histograms, shift 5: exact zero linearity (R2 R3)
    for (int i = 0; i < NC; i++) begin h1[i] = 20; h2[i] = 20; end
    h2[0] = 25;
    run_case("uniform", 0);

    // non-uniform code widths, shift 4
    for (int i = 0; i < NC; i++) begin h1[i] = 12 + (i * 7) % 9; h2[i] = h1[i]; end
    h2[0] = h1[0] + 4;
    run_case("varied", 0);

    // mismatched second histogram with back-pressure
    for (int i = 0; i < NC; i++) begin
      h1[i] = 14 + (i * 5) % 7;
      h2[i] = h1[i] + ((i == 0) ? 3 : ((i % 2 == 1) ? 1 : -1));
    end
    run_case("backpressure", 1);

    // R8 zero counts at code 0 and N-1 are legal
    for (int i = 0; i < NC; i++) begin h1[i] = 20; h2[i] = 20; end
    h1[0] = 0; h2[0] = 5; h1[NC-1] = 0; h2[NC-1] = 0;
    run_case("edge zero", 0);

    // R8 zero count inside the range
    for (int i = 0; i < NC; i++) begin h1[i] = 20; h2[i] = 20; end
    h2[0] = 25; h2[7] = 0;
    run_case("zero bin", 0);

    // R9 no shift: denominator zero at code 1
    for (int i = 0; i < NC; i++) begin h1[i] = 20; h2[i] = 20; end
    run_case("zero shift", 0);

    // recovery after abort
    for (int i = 0; i < NC; i++) begin h1[i] = 12 + (i * 7) % 9; h2[i] = h1[i]; end
    h2[0] = h1[0] + 6;
    run_case("after abort", 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule